// File: doc/BRIEF.md
# Dual Cascadable Event Counter

This block counts edges on two external event pins. Each pin feeds its own 16-bit counter, and each counter has a polarity bit that picks whether rising or falling edges are counted. The pins are asynchronous to the block clock: each one passes through a two-flop synchroniser, and the edge detector works on the synchronised copy. A cascade bit joins the two counters into a single 32-bit counter. In that mode the upper counter advances when the lower one wraps, and the upper pin is ignored.

A host reaches the block through a byte-wide register port. It has a write strobe with address and data, and a separate combinational read address. The host can preload any count byte and can freeze a snapshot of all four count bytes, so that a multi-byte value is read coherently while counting goes on underneath. Every count byte the host reads comes from the snapshot copy. While the snapshot bit is clear, that copy follows the live counters one cycle behind.

The asynchronous active-low reset is released synchronously inside the block. The host should set a polarity bit before it preloads the matching counter.

Top module: `evcp_top`

## Requirements
- R1: After reset every register reads 0. Internal logic leaves reset on the second rising clock edge after `rst_n` rises.
- R2: Address 0 is the control register. Bit 0 is the channel-0 polarity, bit 1 the channel-1 polarity, bit 2 the cascade enable and bit 3 the snapshot hold. A write stores bits 3:0, and bits 7:4 read back as 0.
- R3: With polarity 1 a channel counts rising edges of its pin, and with polarity 0 it counts falling edges. The count changes on the third rising clock edge after the pin changes.
- R4: Each 16-bit counter wraps from FFFFh to 0000h. Outside cascade mode the two counters are fully independent.
- R5: With cascade enabled, channel 1 advances exactly when channel 0 wraps from FFFFh to 0000h, and the channel-1 pin has no effect.
- R6: While the snapshot bit is 0, the readable count bytes show the live count as it was one cycle earlier. Writing the bit to 1 freezes the copy at the count from just before that write's edge. Events that arrive while the copy is frozen are still counted and become visible after the bit is cleared.
- R7: Addresses 1 to 4 hold the channel-0 low byte, channel-0 high byte, channel-1 low byte and channel-1 high byte, in that order. A write to one of them loads that byte of the live counter. The same write discards that counter's event or carry in that cycle.
- R8: Addresses 5 to 7 read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_pin | input | 2 | Event pins, bit 0 for channel 0 |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host write address |
| wr_data | input | 8 | Host write data |
| rd_addr | input | 3 | Host read address |
| rd_data | output | 8 | Read data for rd_addr, combinational |

## Verification
The bench lines up a host write with an event edge in the same cycle. A design that let the event win would leave the written byte off by one. It drives the lower counter through FFFFh while cascade is on and toggles the upper pin, so a design that counted the upper pin, or missed the carry, reads a wrong upper byte. It also counts pulses while the snapshot is held, which exposes a copy that keeps moving or events that get lost. A per-cycle reference model catches any error in the three-edge pin latency or in the one-cycle lag of the readable copy.

// File: rtl/evcp_pkg.sv
package evcp_pkg;
  localparam int NUM_CH    = 2;
  localparam int ADDR_W    = 3;
  localparam int CTRL_ADDR = 0;
  localparam int CNT_BASE  = 1;

  typedef struct packed {
    logic snap;
    logic casc;
    logic pol_b;
    logic pol_a;
  } ctrl_t;
endpackage

// File: rtl/evcp_sync_edge.sv
module evcp_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic pol,
  output logic evt
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              last_q, last_d;
  logic              lvl;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin};
    last_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign lvl = sync_q[STAGES-1];
  assign evt = pol ? (lvl & ~last_q) : (~lvl & last_q);
endmodule

// File: rtl/evcp_counter.sv
module evcp_counter #(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inc,
  input  logic [CNT_W/8-1:0] wr_be,
  input  logic [7:0]         wr_byte,
  output logic [CNT_W-1:0]   cnt,
  output logic               carry
);
  localparam int NB = CNT_W / 8;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             any_wr;

  assign any_wr = |wr_be;
  assign cnt_en = inc | any_wr;

  always_comb begin
    cnt_d = cnt_q;
    if (any_wr) begin
      for (int b = 0; b < NB; b++) begin
        if (wr_be[b]) cnt_d[b*8 +: 8] = wr_byte;
      end
    end else if (inc) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt   = cnt_q;
  assign carry = inc & ~any_wr & (&cnt_q);
endmodule

// File: rtl/evcp_snap.sv
module evcp_snap #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         freeze,
  input  logic [W-1:0] live,
  output logic [W-1:0] held
);
  logic [W-1:0] held_q;
  logic         load_en;

  assign load_en = ~freeze;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held_q <= '0;
    else if (load_en) held_q <= live;
  end

  assign held = held_q;
endmodule

// File: rtl/evcp_regif.sv
module evcp_regif
  import evcp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [ADDR_W-1:0]                   wr_addr,
  input  logic [7:0]                          wr_data,
  input  logic [ADDR_W-1:0]                   rd_addr,
  input  logic [NUM_CH*CNT_W-1:0]             held,
  output ctrl_t                               ctrl,
  output logic [NUM_CH-1:0][CNT_W/8-1:0]      wr_be,
  output logic [7:0]                          rd_data
);
  localparam int NB      = CNT_W / 8;
  localparam int N_BYTES = NUM_CH * NB;

  ctrl_t ctrl_q, ctrl_d;
  logic  ctrl_en;

  assign ctrl_en = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_en) ctrl_d = ctrl_t'(wr_data[3:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  assign ctrl = ctrl_q;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_dec_ch
    for (genvar b = 0; b < NB; b++) begin : g_dec_b
      assign wr_be[ch][b] = wr_en && (wr_addr == ADDR_W'(CNT_BASE + ch*NB + b));
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(CTRL_ADDR)) begin
      rd_data = {4'b0000, ctrl_q};
    end else begin
      for (int k = 0; k < N_BYTES; k++) begin
        if (rd_addr == ADDR_W'(CNT_BASE + k)) rd_data = held[k*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/evcp_top.sv
module evcp_top
  import evcp_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ev_pin,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int NB    = CNT_W / 8;
  localparam int TOT_W = NUM_CH * CNT_W;

  logic rst_meta_q, rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  ctrl_t                         ctrl_q;
  logic [NUM_CH-1:0][NB-1:0]     wr_be;
  logic [TOT_W-1:0]              cnt_all, held_all;
  logic [NUM_CH-1:0]             evt, inc, carry, pol;

  assign pol = {ctrl_q.pol_b, ctrl_q.pol_a};

  evcp_regif #(.CNT_W(CNT_W)) u_regif (
    .clk     (clk),
    .rst_n   (rst_q),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .held    (held_all),
    .ctrl    (ctrl_q),
    .wr_be   (wr_be),
    .rd_data (rd_data)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    evcp_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_q),
      .pin   (ev_pin[ch]),
      .pol   (pol[ch]),
      .evt   (evt[ch])
    );

    if (ch == 0) begin : g_first
      assign inc[ch] = evt[ch];
    end else begin : g_chain
      assign inc[ch] = ctrl_q.casc ? carry[ch-1] : evt[ch];
    end

    evcp_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_q),
      .inc     (inc[ch]),
      .wr_be   (wr_be[ch]),
      .wr_byte (wr_data),
      .cnt     (cnt_all[ch*CNT_W +: CNT_W]),
      .carry   (carry[ch])
    );
  end

  evcp_snap #(.W(TOT_W)) u_snap (
    .clk    (clk),
    .rst_n  (rst_q),
    .freeze (ctrl_q.snap),
    .live   (cnt_all),
    .held   (held_all)
  );
endmodule

// File: rtl/evcp_chk.sv
module evcp_chk
  import evcp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_en,
  input logic [ADDR_W-1:0]         wr_addr,
  input logic [7:0]                wr_data,
  input logic [3:0]                ctrl,
  input logic [NUM_CH*CNT_W-1:0]   cnt_all,
  input logic [NUM_CH*CNT_W-1:0]   held_all,
  input logic [NUM_CH-1:0]         carry
);
  localparam int NB = CNT_W / 8;

  logic hit0, hit1;
  assign hit0 = wr_en && (wr_addr >= ADDR_W'(CNT_BASE)) && (wr_addr < ADDR_W'(CNT_BASE + NB));
  assign hit1 = wr_en && (wr_addr >= ADDR_W'(CNT_BASE + NB)) && (wr_addr < ADDR_W'(CNT_BASE + 2*NB));

  // R2
  ctrl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(CTRL_ADDR)) |=> ctrl == $past(wr_data[3:0]));

  // R7
  preload_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(CNT_BASE)) |=> cnt_all[7:0] == $past(wr_data));

  // R4
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit0 |=> (cnt_all[CNT_W-1:0] == $past(cnt_all[CNT_W-1:0]) ||
               cnt_all[CNT_W-1:0] == $past(cnt_all[CNT_W-1:0]) + CNT_W'(1)));

  // R4
  wrap_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carry[0] |=> cnt_all[CNT_W-1:0] == '0);

  // R4
  wrap_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carry[1] |=> cnt_all[2*CNT_W-1:CNT_W] == '0);

  // R5
  cascade_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[2] && !carry[0] && !hit1) |=> $stable(cnt_all[2*CNT_W-1:CNT_W]));

  // R6
  copy_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[3] |=> held_all == $past(cnt_all));

  // R6
  copy_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[3] && $past(ctrl[3])) |-> $stable(held_all));
endmodule

bind evcp_top evcp_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_q),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .ctrl     (ctrl_q),
  .cnt_all  (cnt_all),
  .held_all (held_all),
  .carry    (carry)
);

// File: tb/test_evcp_top.sv
module test_evcp_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic       clk;
  logic       rst_n;
  logic [1:0] ev_pin;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [2:0] rd_addr;
  logic [7:0] rd_data;

  evcp_top i_evcp_top (
    .clk(clk), .rst_n(rst_n), .ev_pin(ev_pin), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_chk = 0;
  int    n_err = 0;
  int    cyc   = 0;
  bit    cmp_on = 0;
  int    force_addr = -1;
  string cur_req = "R1";

  // behavioural reference model
  int m_ctrl = 0;
  int m_cnt[2];
  int m_hold[2];
  int p1[2], p2[2], p3[2];
  int rf = 0, rq = 0;

  always @(posedge clk) begin : model
    int old_rq;
    int ev[2];
    int hit[2];
    int incv[2];
    int cy;
    old_rq = rq;
    if (!rst_n) begin rf = 0; rq = 0; end
    else begin rq = rf; rf = 1; end
    if (!rst_n || old_rq == 0) begin
      m_ctrl = 0;
      for (int c = 0; c < 2; c++) begin
        m_cnt[c] = 0; m_hold[c] = 0; p1[c] = 0; p2[c] = 0; p3[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (((m_ctrl >> c) & 1) == 1) ev[c] = (p2[c] == 1 && p3[c] == 0) ? 1 : 0;
        else                          ev[c] = (p2[c] == 0 && p3[c] == 1) ? 1 : 0;
        p3[c] = p2[c]; p2[c] = p1[c]; p1[c] = int'(ev_pin[c]);
        hit[c] = (wr_en && int'(wr_addr) >= 1 + 2*c && int'(wr_addr) <= 2 + 2*c) ? 1 : 0;
      end
      incv[0] = (ev[0] == 1 && hit[0] == 0) ? 1 : 0;
      cy = (incv[0] == 1 && m_cnt[0] == 65535) ? 1 : 0;
      incv[1] = ((m_ctrl & 4) != 0) ? cy : ev[1];
      if (hit[1] == 1) incv[1] = 0;
      if ((m_ctrl & 8) == 0) begin
        m_hold[0] = m_cnt[0]; m_hold[1] = m_cnt[1];
      end
      for (int c = 0; c < 2; c++) begin
        if (hit[c] == 1) begin
          int sh;
          sh = 8 * (int'(wr_addr) - 1 - 2*c);
          m_cnt[c] = (m_cnt[c] & ~(255 << sh)) | (int'(wr_data) << sh);
        end else begin
          m_cnt[c] = (m_cnt[c] + incv[c]) & 65535;
        end
      end
      if (wr_en && wr_addr == 3'd0) m_ctrl = int'(wr_data) & 15;
    end
  end

  function automatic int exp_rd(int a);
    if (a == 0) return m_ctrl;
    if (a >= 1 && a <= 4) return (m_hold[(a-1)/2] >> (8*((a-1)%2))) & 255;
    return 0;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) chk(int'(rd_data) == exp_rd(int'(rd_addr)), cur_req, int'(rd_data), exp_rd(int'(rd_addr)));
    if (force_addr >= 0) rd_addr <= 3'(force_addr);
    else                 rd_addr <= rd_addr + 3'd1;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WATCHDOG) begin
      n_err++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(int c, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ev_pin[c] = 1'b1;
      repeat (3) @(negedge clk);
      ev_pin[c] = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic peek(int a, int exp, string tag);
    force_addr = a;
    repeat (3) @(negedge clk);
    chk(int'(rd_data) == exp, tag, int'(rd_data), exp);
    force_addr = -1;
  endtask

  initial begin
    rst_n = 1'b0; ev_pin = 2'b00; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cmp_on = 1;

    cur_req = "R1";
    repeat (10) @(negedge clk);
    peek(0, 0, "R1"); peek(2, 0, "R1"); peek(4, 0, "R1");

    cur_req = "R2";
    wr(0, 8'hF3);
    peek(0, 8'h03, "R2");
    wr(0, 8'h01);
    peek(0, 8'h01, "R2");

    cur_req = "R3";
    pulse(0, 3);
    pulse(1, 2);
    repeat (4) @(negedge clk);
    peek(1, 3, "R3 rising count");
    peek(3, 2, "R3 falling count");

    cur_req = "R7";
    @(negedge clk); ev_pin[0] = 1'b1;
    @(negedge clk);
    wr(1, 8'h10);
    @(negedge clk); ev_pin[0] = 1'b0;
    repeat (4) @(negedge clk);
    peek(1, 8'h10, "R7 write beats event");
    peek(2, 8'h00, "R7 high byte untouched");
    wr(1, 8'hFE); wr(2, 8'hFF);
    peek(2, 8'hFF, "R7 preload high");

    cur_req = "R4";
    pulse(0, 2);
    repeat (4) @(negedge clk);
    peek(1, 0, "R4 wrap low");
    peek(2, 0, "R4 wrap high");
    peek(3, 2, "R4 other channel unchanged");

    cur_req = "R5";
    wr(0, 8'h05);
    wr(1, 8'hFF); wr(2, 8'hFF); wr(3, 8'h12); wr(4, 8'h00);
    pulse(1, 2);
    repeat (4) @(negedge clk);
    peek(3, 8'h12, "R5 pin ignored");
    pulse(0, 1);
    repeat (4) @(negedge clk);
    peek(3, 8'h13, "R5 carry counted");
    peek(1, 0, "R5 low wrapped");

    cur_req = "R6";
    wr(0, 8'h0D);
    pulse(0, 4);
    repeat (4) @(negedge clk);
    peek(1, 0, "R6 copy frozen");
    peek(3, 8'h13, "R6 copy frozen");
    wr(0, 8'h05);
    peek(1, 4, "R6 no event lost");

    cur_req = "R8";
    wr(6, 8'hAA);
    peek(5, 0, "R8"); peek(6, 0, "R8"); peek(7, 0, "R8");
    peek(0, 8'h05, "R8 control unchanged");
    peek(1, 4, "R8 count unchanged");

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule